// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt controller of a small 16-bit processor core. At each instruction boundary it looks at the pending interrupt sources and picks one by a fixed priority. Each source has its own type number. The block then saves the machine state on the stack through a word-wide memory port. It pushes the flags, then the code segment, then the instruction pointer, and steps SP down by two before each write. After the flags word is written, it clears the interrupt-enable and trap bits in its working copy of the flags. It then reads the handler's IP and CS from the vector table at type×4.

A return request runs the opposite sequence. It pops IP, CS and flags, and steps SP up by two after each read. In both directions the block ends with a one-cycle update strobe. The core copies the new SP, CS, IP and flags into its registers on that strobe. The core also stalls while `busy` is high.

The flags word uses these bit positions: TF at bit 8, IF at bit 9, OF at bit 11. Physical addresses are segment×16 plus offset, wrapped to 20 bits. Stack accesses use the stack segment sampled when the sequence starts. Vector table accesses use segment zero.

Top module: `intr_seq`

## Requirements
- R1: On entry the block writes three words at stack offsets SP-2, SP-4 and SP-6, in that order: the sampled flags, then CS, then IP. The SP output ends at SP-6.
- R2: The pushed flags word is the value sampled at acceptance. The final flags output equals that value with bit 9 (IF) and bit 8 (TF) cleared.
- R3: For type n, the block reads the new IP from physical address 4n and the new CS from 4n+2. These become the IP and CS outputs.
- R4: When several sources request at one boundary, they are served in this order, highest first: divide error, software interrupt, overflow trap, NMI, maskable INTR, single-step. Lower requests that stay asserted are served at later boundaries.
- R5: Each source has a fixed type number, reported on `vec_type`: divide error 0, single-step 1, NMI 2, overflow trap 4. A software interrupt uses `sw_type` and INTR uses `intr_type`; both are sampled in the cycle the request is accepted.
- R6: An overflow trap request while OF (bit 11) is 0 starts no sequence and makes no memory access.
- R7: A rising edge on `nmi` sets a pending latch. The latch is served at a later boundary and cleared when served. Holding `nmi` high gives only one entry.
- R8: INTR is accepted only at a boundary while IF (bit 9) is 1. Acceptance is shown by a one-cycle `intr_ack`. While IF is 0, INTR causes no entry and no acknowledge.
- R9: With TF (bit 8) set and no other source requesting, a boundary starts a type-1 entry.
- R10: A return request reads IP at SP, CS at SP+2 and flags at SP+4, in that order. The SP output ends at SP+6, and the IP, CS and flags outputs take the values read.
- R11: `busy` is high from the cycle after acceptance until the update strobe. Boundaries and requests seen while busy are ignored.
- R12: Physical addresses wrap modulo 2^20.
- R13: `upd_valid` is a single-cycle pulse at the end of every entry or return sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| div_err | input | 1 | Divide error request |
| sw_int | input | 1 | Software interrupt request |
| sw_type | input | 8 | Software interrupt type |
| ovf_trap | input | 1 | Overflow trap request |
| nmi | input | 1 | Non-maskable request, edge captured |
| intr | input | 1 | Maskable level request |
| intr_type | input | 8 | Type supplied with INTR |
| intr_ack | output | 1 | INTR accepted |
| iret_req | input | 1 | Return request |
| flags_in | input | 16 | Current flags |
| ss_in | input | 16 | Stack segment |
| sp_in | input | 16 | Current SP |
| cs_in | input | 16 | Current CS |
| ip_in | input | 16 | Current IP |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| upd_valid | output | 1 | Load the updated registers |
| vec_type | output | 8 | Type number of the last entry |
| flags_out | output | 16 | Updated flags |
| sp_out | output | 16 | Updated SP |
| cs_out | output | 16 | Updated CS |
| ip_out | output | 16 | Updated IP |

## Verification
A wrong arbitration choice shows up two ways: the reported type and the address of the vector read, which appears four accesses after acceptance. A bad SP step or segment calculation shows up at once in the address of the first push. A flags-clearing error only becomes visible at the update strobe, about six cycles after acceptance. A lost or repeated NMI pending bit is visible as a missing or extra sequence at the next boundary. So each scenario observes the whole memory trace and a few idle cycles after the strobe.

// File: rtl/intr_seq.sv
module intr_seq #(
  parameter int TF_BIT = 8,
  parameter int IF_BIT = 9,
  parameter int OF_BIT = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary,
  input  logic        div_err,
  input  logic        sw_int,
  input  logic [7:0]  sw_type,
  input  logic        ovf_trap,
  input  logic        nmi,
  input  logic        intr,
  input  logic [7:0]  intr_type,
  output logic        intr_ack,
  input  logic        iret_req,
  input  logic [15:0] flags_in,
  input  logic [15:0] ss_in,
  input  logic [15:0] sp_in,
  input  logic [15:0] cs_in,
  input  logic [15:0] ip_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [19:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_rdy,
  output logic        busy,
  output logic        upd_valid,
  output logic [7:0]  vec_type,
  output logic [15:0] flags_out,
  output logic [15:0] sp_out,
  output logic [15:0] cs_out,
  output logic [15:0] ip_out
);

  typedef enum logic [3:0] {
    S_IDLE, S_PF, S_PC, S_PI, S_RI, S_RC, S_OI, S_OC, S_OF, S_DONE
  } st_t;

  localparam logic [15:0] CLR_MASK = ~((16'd1 << IF_BIT) | (16'd1 << TF_BIT));

  st_t         state;
  logic [15:0] ss_r, sp_r, cs_r, ip_r, fl_r;
  logic [7:0]  typ_r;
  logic        nmi_d, nmi_pend;

  logic        take, nmi_take, ret_take;
  logic [7:0]  tsel;
  logic [15:0] seg, off;

  assign busy      = state != S_IDLE;
  assign upd_valid = state == S_DONE;
  assign vec_type  = typ_r;
  assign flags_out = fl_r;
  assign sp_out    = sp_r;
  assign cs_out    = cs_r;
  assign ip_out    = ip_r;
  assign ret_take  = (state == S_IDLE) && iret_req;

  always_comb begin
    take = 1'b0;
    nmi_take = 1'b0;
    intr_ack = 1'b0;
    tsel = 8'd0;
    if (state == S_IDLE && !iret_req && boundary) begin
      if (div_err) begin
        take = 1'b1; tsel = 8'd0;
      end else if (sw_int) begin
        take = 1'b1; tsel = sw_type;
      end else if (ovf_trap && flags_in[OF_BIT]) begin
        take = 1'b1; tsel = 8'd4;
      end else if (nmi_pend) begin
        take = 1'b1; tsel = 8'd2; nmi_take = 1'b1;
      end else if (intr && flags_in[IF_BIT]) begin
        take = 1'b1; tsel = intr_type; intr_ack = 1'b1;
      end else if (flags_in[TF_BIT]) begin
        take = 1'b1; tsel = 8'd1;
      end
    end
  end

  always_comb begin
    mem_req = 1'b1;
    mem_we = 1'b0;
    mem_wdata = 16'd0;
    seg = ss_r;
    off = sp_r;
    case (state)
      S_PF: begin mem_we = 1'b1; off = sp_r - 16'd2; mem_wdata = fl_r; end
      S_PC: begin mem_we = 1'b1; off = sp_r - 16'd2; mem_wdata = cs_r; end
      S_PI: begin mem_we = 1'b1; off = sp_r - 16'd2; mem_wdata = ip_r; end
      S_RI: begin seg = 16'd0; off = {6'd0, typ_r, 2'b00}; end
      S_RC: begin seg = 16'd0; off = {6'd0, typ_r, 2'b10}; end
      S_OI, S_OC, S_OF: ;
      default: mem_req = 1'b0;
    endcase
  end

  assign mem_addr = {seg, 4'h0} + {4'h0, off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_d <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_d <= nmi;
      nmi_pend <= (nmi & ~nmi_d) | (nmi_pend & ~nmi_take);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ss_r <= 16'd0; sp_r <= 16'd0; cs_r <= 16'd0; ip_r <= 16'd0; fl_r <= 16'd0;
      typ_r <= 8'd0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ret_take || take) begin
            ss_r <= ss_in; sp_r <= sp_in; cs_r <= cs_in; ip_r <= ip_in; fl_r <= flags_in;
          end
          if (ret_take) state <= S_OI;
          else if (take) begin
            typ_r <= tsel;
            state <= S_PF;
          end
        end
        S_PF: if (mem_rdy) begin
          sp_r <= sp_r - 16'd2; fl_r <= fl_r & CLR_MASK; state <= S_PC;
        end
        S_PC: if (mem_rdy) begin sp_r <= sp_r - 16'd2; state <= S_PI; end
        S_PI: if (mem_rdy) begin sp_r <= sp_r - 16'd2; state <= S_RI; end
        S_RI: if (mem_rdy) begin ip_r <= mem_rdata; state <= S_RC; end
        S_RC: if (mem_rdy) begin cs_r <= mem_rdata; state <= S_DONE; end
        S_OI: if (mem_rdy) begin ip_r <= mem_rdata; sp_r <= sp_r + 16'd2; state <= S_OC; end
        S_OC: if (mem_rdy) begin cs_r <= mem_rdata; sp_r <= sp_r + 16'd2; state <= S_OF; end
        S_OF: if (mem_rdy) begin fl_r <= mem_rdata; sp_r <= sp_r + 16'd2; state <= S_DONE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_PUSH_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {S_PF, S_PC, S_PI}) && mem_rdy |=> sp_r == $past(sp_r) - 16'd2); // R1
  AST_IFTF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PC) |-> !fl_r[IF_BIT] && !fl_r[TF_BIT]); // R2
  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RI) |-> mem_addr[1:0] == 2'b00 && mem_addr[19:10] == 10'd0); // R3
  AST_ACK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ack |-> flags_in[IF_BIT] && boundary && !busy); // R8
  AST_POP_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {S_OI, S_OC, S_OF}) && mem_rdy |=> sp_r == $past(sp_r) + 16'd2); // R10
  AST_MEM_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R11
  AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid); // R13

endmodule

// File: tb/tb_intr_seq.sv
module tb_intr_seq;
  logic clk = 0, rst_n = 0;
  logic boundary = 0, div_err = 0, sw_int = 0, ovf_trap = 0, nmi = 0, intr = 0, iret_req = 0;
  logic [7:0] sw_type = 0, intr_type = 0, vec_type;
  logic [15:0] flags_in = 0, ss_in = 16'h1000, sp_in = 16'h0100, cs_in = 16'h2000, ip_in = 16'h0345;
  logic mem_req, mem_we, mem_rdy, busy, upd_valid, intr_ack;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, flags_out, sp_out, cs_out, ip_out;

  logic [15:0] vec_mem [0:511];
  logic [15:0] stk_mem [0:255];
  int checks = 0, errors = 0;
  int n_wr = 0, n_acc = 0, busy_cnt = 0;
  logic [19:0] wr_a [0:7];
  logic [15:0] wr_d [0:7];
  logic [19:0] rd_a [0:7];
  int n_rd = 0;

  always #5 clk = ~clk;
  assign mem_rdy = 1'b1;
  assign mem_rdata = (mem_addr[19:10] == 10'd0) ? vec_mem[mem_addr[9:1]] : stk_mem[mem_addr[8:1]];

  intr_seq dut (.*);

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (mem_req && mem_rdy) begin
      n_acc++;
      if (mem_we) begin
        if (n_wr < 8) begin wr_a[n_wr] = mem_addr; wr_d[n_wr] = mem_wdata; end
        n_wr++;
        if (mem_addr[19:10] == 10'd0) vec_mem[mem_addr[9:1]] = mem_wdata;
        else stk_mem[mem_addr[8:1]] = mem_wdata;
      end else begin
        if (n_rd < 8) rd_a[n_rd] = mem_addr;
        n_rd++;
      end
    end
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    n_wr = 0; n_rd = 0; n_acc = 0; busy_cnt = 0;
  endtask

  // drive one boundary cycle; returns intr_ack seen in that cycle
  task automatic bnd(output logic ack);
    @(negedge clk);
    boundary = 1;
    #1 ack = intr_ack;
    @(negedge clk);
    boundary = 0; div_err = 0; sw_int = 0; ovf_trap = 0;
  endtask

  task automatic wait_upd(string req);
    int k;
    for (k = 0; k < 30 && !upd_valid; k++) @(negedge clk);
    chk(req, {31'd0, upd_valid}, 32'd1);
    @(negedge clk);
  endtask

  task automatic chk_entry(string req, logic [7:0] t, logic [15:0] fl0);
    chk({req, " R5 type"}, vec_type, t);
    chk("R3 ip", ip_out, 16'hA000 + 16'(2 * t));
    chk("R3 cs", cs_out, 16'hA001 + 16'(2 * t));
    chk("R3 vec read addr", rd_a[0], 20'(4 * t));
    chk("R2 flags out", flags_out, fl0 & 16'hFCFF);
    chk("R1 sp", sp_out, sp_in - 16'd6);
  endtask

  task automatic idle_quiet(string req);
    repeat (8) @(negedge clk);
    chk({req, " no busy"}, busy_cnt, 0);
    chk({req, " no access"}, n_acc, 0);
  endtask

  task automatic t_reset();
    chk("R11 reset busy", {31'd0, busy}, 0);
    chk("R13 reset upd", {31'd0, upd_valid}, 0);
    chk("R11 reset mem_req", {31'd0, mem_req}, 0);
  endtask

  task automatic t_swint();
    logic a;
    clr_log();
    flags_in = 16'h0302; sw_int = 1; sw_type = 8'h12;
    bnd(a);
    wait_upd("R13 sw upd");
    chk_entry("R5 sw", 8'h12, 16'h0302);
    chk("R1 nwr", n_wr, 3);
    chk("R1 push0 addr", wr_a[0], 20'h100FE);
    chk("R2 push0 data", wr_d[0], 16'h0302);
    chk("R1 push1 addr", wr_a[1], 20'h100FC);
    chk("R1 push1 data", wr_d[1], 16'h2000);
    chk("R1 push2 addr", wr_a[2], 20'h100FA);
    chk("R1 push2 data", wr_d[2], 16'h0345);
    chk("R3 cs read addr", rd_a[1], 20'h0004A);
    chk("R11 busy length", busy_cnt, 6);
  endtask

  task automatic t_iret();
    logic a;
    clr_log();
    sp_in = 16'h00FA;
    @(negedge clk); iret_req = 1; @(negedge clk); iret_req = 0;
    wait_upd("R13 iret upd");
    chk("R10 ip", ip_out, 16'h0345);
    chk("R10 cs", cs_out, 16'h2000);
    chk("R10 flags", flags_out, 16'h0302);
    chk("R10 sp", sp_out, 16'h0100);
    chk("R10 rd0", rd_a[0], 20'h100FA);
    chk("R10 rd1", rd_a[1], 20'h100FC);
    chk("R10 rd2", rd_a[2], 20'h100FE);
    chk("R10 no writes", n_wr, 0);
    sp_in = 16'h0100;
  endtask

  task automatic t_priority();
    logic a;
    flags_in = 16'h0300;
    clr_log(); @(negedge clk); nmi = 1;
    intr = 1; intr_type = 8'h20; div_err = 1;
    bnd(a); wait_upd("R4 upd div");
    chk_entry("R4 div first", 8'd0, 16'h0300);
    chk("R8 no ack when lower", {31'd0, a}, 0);
    clr_log(); bnd(a); wait_upd("R7 upd nmi");
    chk_entry("R7 nmi second", 8'd2, 16'h0300);
    clr_log(); bnd(a); wait_upd("R8 upd intr");
    chk_entry("R8 intr third", 8'h20, 16'h0300);
    chk("R8 ack", {31'd0, a}, 1);
    intr = 0;
    clr_log(); bnd(a); wait_upd("R9 upd step");
    chk_entry("R9 step last", 8'd1, 16'h0300);
    flags_in = 16'h0000;
    clr_log(); bnd(a); idle_quiet("R7 nmi held one entry");
    nmi = 0;
  endtask

  task automatic t_ovf();
    logic a;
    flags_in = 16'h0000;
    clr_log(); ovf_trap = 1; bnd(a); idle_quiet("R6 ovf OF=0");
    flags_in = 16'h0800;
    clr_log(); ovf_trap = 1; bnd(a); wait_upd("R6 upd ovf");
    chk_entry("R6 ovf OF=1", 8'd4, 16'h0800);
    flags_in = 16'h0900;
    clr_log(); ovf_trap = 1; sw_int = 1; sw_type = 8'h30; bnd(a); wait_upd("R4 upd sw");
    chk_entry("R4 sw over ovf", 8'h30, 16'h0900);
  endtask

  task automatic t_mask();
    logic a;
    flags_in = 16'h0000; intr = 1; intr_type = 8'h41;
    clr_log(); bnd(a);
    chk("R8 no ack masked", {31'd0, a}, 0);
    idle_quiet("R8 masked");
    flags_in = 16'h0200;
    clr_log(); bnd(a);
    chk("R8 ack unmasked", {31'd0, a}, 1);
    intr = 0;
    wait_upd("R8 upd");
    chk_entry("R5 intr type", 8'h41, 16'h0200);
  endtask

  task automatic t_busy();
    logic a;
    flags_in = 16'h0000;
    clr_log(); sw_int = 1; sw_type = 8'h12;
    bnd(a);
    boundary = 1; div_err = 1; ovf_trap = 1;
    @(negedge clk);
    boundary = 0; div_err = 0; ovf_trap = 0;
    wait_upd("R11 upd");
    chk_entry("R11 first kept", 8'h12, 16'h0000);
    clr_log(); idle_quiet("R11 request while busy dropped");
  endtask

  task automatic t_wrap();
    logic a;
    ss_in = 16'hFFFF; sp_in = 16'h0020; flags_in = 16'h0000;
    clr_log(); sw_int = 1; sw_type = 8'h12;
    bnd(a); wait_upd("R12 upd");
    chk("R12 wrap push0", wr_a[0], 20'h0000E);
    chk("R12 wrap push1", wr_a[1], 20'h0000C);
    chk("R12 wrap push2", wr_a[2], 20'h0000A);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) vec_mem[i] = 16'hA000 + 16'(i);
    for (int i = 0; i < 256; i++) stk_mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_swint();
    t_iret();
    t_priority();
    t_ovf();
    t_mask();
    t_busy();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule